// File: doc/BRIEF.md
# Strobe-Clocked Programmable Read-Only Byte Store

This block is a 512-byte one-time-programmable store that is read through a single chip-select strobe. A falling transition of the strobe latches the word address and switches the row and column decoders on. The rising transition then loads the addressed byte into an output holding register. A read therefore takes two strobe phases. While the strobe stays high the held byte does not change, which lets a host pipeline one fetch behind the next.

Three output-enable inputs control whether the held byte is presented: two are active low and one is active high. This gating is independent of the strobe. The tri-state pad sits outside the block, which supplies the data together with a drive-enable. Programming goes through a separate path. While a program-enable level is high, each pulse on a program strobe ORs an 8-bit mask into the byte at the latched address, and reads are suppressed. Signal edges are detected against the block clock, and everything is synchronous to that clock.

Top module: `prom_rd_port`

## Requirements
- R1: Asynchronous reset clears the output holding register to 0x00, clears the latched address to 0 and puts the strobe into its inactive (high) state.
- R2: Every byte of a freshly reset array reads as 0x00.
- R3: The address is captured in the clock cycle where `ce_i` is first seen low after being high; later changes on `addr_i` while `ce_i` stays low have no effect on the byte that is read.
- R4: The output register loads the addressed byte in the cycle where `ce_i` is first seen high after being low, and holds it unchanged while `ce_i` stays high, whatever `addr_i` does.
- R5: Address bits [8:3] select one of 64 rows of 64 bits, and bits [2:0] select byte lane `addr[2:0]` (bits `8*addr[2:0]+7` down to `8*addr[2:0]`) within that row; programming one byte never alters its neighbours.
- R6: `q_oe_o` is 1 exactly when `oe_a_ni`=0, `oe_b_ni`=0 and `oe_c_i`=1, regardless of `ce_i`; when it is 0, `q_o` reads 0x00; when it is 1, `q_o` equals the holding register.
- R7: With `ce_i` low (decoders on) and `prog_en_i`=1, each cycle with `prog_stb_i`=1 ORs `prog_mask_i` into the byte at the latched address; a bit that is 1 never returns to 0, so a zero mask changes nothing.
- R8: While `prog_en_i`=1, a rising strobe does not load the output register; it keeps its previous value.
- R9: While the strobe is high (standby, decoders off), a program strobe has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip-select strobe, active low |
| addr_i | input | 9 | Byte address |
| oe_a_ni | input | 1 | Output enable A, active low |
| oe_b_ni | input | 1 | Output enable B, active low |
| oe_c_i | input | 1 | Output enable C, active high |
| prog_en_i | input | 1 | Programming mode level |
| prog_stb_i | input | 1 | Program pulse, one OR per cycle |
| prog_mask_i | input | 8 | Bits to set in the addressed byte |
| q_o | output | 8 | Held byte, zero when not enabled |
| q_oe_o | output | 1 | Drive enable for the external tri-state pad |

## Verification
The bench builds the block with its default geometry: 6 row bits, 3 column bits and 8-bit words. This puts the extreme rows (0 and 63) and all eight byte lanes within reach, including the lane-7/lane-0 boundary between adjacent addresses 0x007 and 0x008. With that geometry the bench can OR two masks into a single byte, read back a zero-mask program, and drive all eight output-enable combinations against a shadow model of the byte store.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int unsigned ROW_BITS_DEF = 6;
  localparam int unsigned COL_BITS_DEF = 3;
  localparam int unsigned WORD_W_DEF   = 8;

  typedef enum logic [1:0] {
    STB_IDLE = 2'b00,
    STB_FALL = 2'b01,
    STB_RISE = 2'b10
  } stb_evt_e;
endpackage

// File: rtl/prom_decode.sv
module prom_decode #(
  parameter int unsigned IN_W  = 3,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IN_W-1:0]  sel_i,
  output logic [OUT_N-1:0] line_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign line_o[i] = en_i && (sel_i == IN_W'(i));
  end

  // R5: at most one line active
  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_o));
  // R9: no line active in standby
  p_standby_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (line_o == '0));
endmodule

// File: rtl/prom_array.sv
module prom_array #(
  parameter int unsigned ROWS   = 64,
  parameter int unsigned LANES  = 8,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned ROW_W = LANES * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROWS-1:0]   row_sel_i,
  input  logic [LANES-1:0]  col_sel_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic [WORD_W-1:0] rd_byte_o
);
  logic [ROW_W-1:0] rows_q   [ROWS];
  logic [ROW_W-1:0] row_gate [ROWS];
  logic [ROW_W-1:0] set_bits;
  logic [ROW_W-1:0] row_word;

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    assign set_bits[c*WORD_W +: WORD_W] = {WORD_W{col_sel_i[c]}} & mask_i;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   rows_q[r] <= '0;
      else if (wr_i && row_sel_i[r]) rows_q[r] <= rows_q[r] | set_bits;
    end
    assign row_gate[r] = row_sel_i[r] ? rows_q[r] : '0;

    // R7: programmed bits are sticky
    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && row_sel_i[r]) |=> ((rows_q[r] & $past(rows_q[r])) == $past(rows_q[r])));
  end

  always_comb begin
    row_word = '0;
    for (int r = 0; r < ROWS; r++) row_word = row_word | row_gate[r];
  end

  always_comb begin
    rd_byte_o = '0;
    for (int c = 0; c < LANES; c++)
      rd_byte_o = rd_byte_o | ({WORD_W{col_sel_i[c]}} & row_word[c*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/prom_out.sv
module prom_out #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] byte_i,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni,
  input  logic              oe_c_i,
  output logic [WORD_W-1:0] q_o,
  output logic              q_oe_o
);
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= byte_i;
  end

  assign q_oe_o = !oe_a_ni && !oe_b_ni && oe_c_i;
  assign q_o    = q_oe_o ? hold_q : '0;

  // R6: disabled output shows zero
  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_oe_o |-> (q_o == '0));
  // R4: holding register changes only on a capture
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(hold_q));
endmodule

// File: rtl/prom_rd_port.sv
module prom_rd_port
  import prom_pkg::*;
#(
  parameter int unsigned ROW_BITS = ROW_BITS_DEF,
  parameter int unsigned COL_BITS = COL_BITS_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF,
  localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS    = 1 << ROW_BITS,
  localparam int unsigned LANES   = 1 << COL_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [8:0]        addr_i,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni,
  input  logic              oe_c_i,
  input  logic              prog_en_i,
  input  logic              prog_stb_i,
  input  logic [7:0]        prog_mask_i,
  output logic [7:0]        q_o,
  output logic              q_oe_o
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;
  stb_evt_e          evt;
  logic              access;
  logic              wr;
  logic              cap;
  logic [ROWS-1:0]   row_sel;
  logic [LANES-1:0]  col_sel;
  logic [WORD_W-1:0] rd_byte;

  always_comb begin
    if (ce_q && !ce_i)      evt = STB_FALL;
    else if (!ce_q && ce_i) evt = STB_RISE;
    else                    evt = STB_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      ce_q <= ce_i;
      if (evt == STB_FALL) addr_q <= ADDR_W'(addr_i);
    end
  end

  assign access = !ce_q;
  assign wr     = access && prog_en_i && prog_stb_i;
  assign cap    = (evt == STB_RISE) && !prog_en_i;

  prom_decode #(.IN_W(ROW_BITS)) u_row_dec (
    .clk_i, .rst_ni, .en_i(access),
    .sel_i(addr_q[ADDR_W-1:COL_BITS]), .line_o(row_sel)
  );

  prom_decode #(.IN_W(COL_BITS)) u_col_dec (
    .clk_i, .rst_ni, .en_i(access),
    .sel_i(addr_q[COL_BITS-1:0]), .line_o(col_sel)
  );

  prom_array #(.ROWS(ROWS), .LANES(LANES), .WORD_W(WORD_W)) u_array (
    .clk_i, .rst_ni, .row_sel_i(row_sel), .col_sel_i(col_sel),
    .wr_i(wr), .mask_i(WORD_W'(prog_mask_i)), .rd_byte_o(rd_byte)
  );

  logic [WORD_W-1:0] q_int;

  prom_out #(.WORD_W(WORD_W)) u_out (
    .clk_i, .rst_ni, .cap_i(cap), .byte_i(rd_byte),
    .oe_a_ni, .oe_b_ni, .oe_c_i, .q_o(q_int), .q_oe_o
  );

  assign q_o = 8'(q_int);

  // R3: address register moves only on a falling strobe
  p_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_q && !ce_i) |=> $stable(addr_q));
  // R8: no load into the output while programming
  p_noread_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && q_oe_o) |=> ($stable(q_o) || $changed({oe_a_ni, oe_b_ni, oe_c_i})));
endmodule

// File: tb/sim_prom_rd_port.sv
module sim_prom_rd_port;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b1;
  logic [8:0] addr = '0;
  logic       oe_a_n = 1'b0, oe_b_n = 1'b0, oe_c = 1'b1;
  logic       prog_en = 1'b0, prog_stb = 1'b0;
  logic [7:0] prog_mask = '0;
  logic [7:0] q;
  logic       q_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [512];

  // {addr[8:0], mask[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {9'h000, 8'h01}, {9'h1FF, 8'h80}, {9'h007, 8'h3C}, {9'h008, 8'hC3},
    {9'h0F8, 8'h5A}, {9'h007, 8'h41}, {9'h100, 8'hFF}, {9'h1FF, 8'h00}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_rd_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .addr_i(addr),
    .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n), .oe_c_i(oe_c),
    .prog_en_i(prog_en), .prog_stb_i(prog_stb), .prog_mask_i(prog_mask),
    .q_o(q), .q_oe_o(q_oe)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [8:0] a);
    @(negedge clk); ce = 1'b0; addr = a;
    @(negedge clk); ce = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic do_prog(input logic [8:0] a, input logic [7:0] m);
    @(negedge clk); ce = 1'b0; addr = a;
    @(negedge clk); prog_en = 1'b1; prog_stb = 1'b1; prog_mask = m;
    @(negedge clk); prog_stb = 1'b0; prog_en = 1'b0;
    @(negedge clk); ce = 1'b1;
    model[a] = model[a] | m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset q", {1'b0, q}, 9'h000);
    check("R6 reset oe", {8'h00, q_oe}, 9'h001);
    rst_n = 1'b1;

    // R2 blank array
    do_read(9'h1A5);
    check("R2 blank 1A5", {1'b0, q}, 9'h000);
    do_read(9'h000);
    check("R2 blank 000", {1'b0, q}, 9'h000);

    // R7 / R5 table walk
    for (int i = 0; i < 8; i++) do_prog(VEC[i][16:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) begin
      do_read(VEC[i][16:8]);
      check("R7 R5 table", {1'b0, q}, {1'b0, model[VEC[i][16:8]]});
    end
    do_read(9'h007);
    check("R7 OR accumulate", {1'b0, q}, 9'h07D);
    do_read(9'h1FF);
    check("R7 zero mask sticky", {1'b0, q}, 9'h080);
    do_read(9'h006);
    check("R5 lane neighbour 006", {1'b0, q}, 9'h000);
    do_read(9'h009);
    check("R5 lane neighbour 009", {1'b0, q}, 9'h000);
    do_read(9'h0F9);
    check("R5 row neighbour 0F9", {1'b0, q}, 9'h000);

    // R3 address change while strobe low
    @(negedge clk); ce = 1'b0; addr = 9'h007;
    @(negedge clk); addr = 9'h100;
    @(negedge clk); addr = 9'h1FF; ce = 1'b1;
    @(negedge clk); #1;
    check("R3 late address ignored", {1'b0, q}, 9'h07D);

    // R4 hold while high
    addr = 9'h100;
    repeat (3) @(negedge clk);
    #1;
    check("R4 held while high", {1'b0, q}, 9'h07D);

    // R6 enable combinations, strobe low to show independence
    @(negedge clk); ce = 1'b0; addr = 9'h0F8;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {oe_a_n, oe_b_n, oe_c} = 3'(k);
      #1;
      if (k == 1) check("R6 enabled", {q_oe, q}, 9'h17D);
      else        check("R6 disabled", {q_oe, q}, 9'h000);
    end
    @(negedge clk); oe_a_n = 1'b0; oe_b_n = 1'b0; oe_c = 1'b1; ce = 1'b1;
    @(negedge clk); #1;
    check("R4 load on rise", {1'b0, q}, 9'h05A);

    // R8 no load while programming
    do_read(9'h008);
    @(negedge clk); ce = 1'b0; addr = 9'h100;
    @(negedge clk); prog_en = 1'b1;
    @(negedge clk); ce = 1'b1;
    @(negedge clk); #1;
    check("R8 read suppressed", {1'b0, q}, 9'h0C3);
    prog_en = 1'b0;

    // R9 program strobe in standby
    do_read(9'h0AA);
    @(negedge clk); prog_en = 1'b1; prog_stb = 1'b1; prog_mask = 8'hFF;
    @(negedge clk); prog_en = 1'b0; prog_stb = 1'b0;
    do_read(9'h0AA);
    check("R9 standby program ignored", {1'b0, q}, 9'h000);

    // R1 reset again clears output register
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 reset clears q", {1'b0, q}, 9'h000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule